// File: doc/BRIEF.md
# Write-Through Invalidate Cache Coherence Controller

This block sits between one processor and a shared bus in a multiprocessor. It keeps a small direct-mapped cache of single-word lines coherent by writing every store through to global memory and by telling every other cache to drop its copy of the stored address. Each line is either valid, meaning it matches global memory, or invalid. A processor load that finds a valid line with a matching tag is answered locally. Any other access takes ownership of the bus and runs a short fixed sequence of bus commands.

Stores always allocate. A store to an absent line first fetches the word. It then broadcasts an invalidate, writes memory, and leaves the local line valid with the new value. Memory never holds stale data, so replacing a line never writes anything back.

The controller also watches invalidate commands that other caches put on the bus. A matching valid line is dropped. Commands that carry this cache's own source number are ignored.

Top module: `wti_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpu_ready` and `bus_req` are low, and `bus_cmd` is 0 (idle). The first load to any address therefore goes to the bus.
- R2: A load to a valid line whose tag matches raises `cpu_ready` in the same cycle as `cpu_valid`. It returns the line's data and issues no bus command.
- R3: A load that misses does the following, in order:
  - it issues one read (`bus_cmd` = 1);
  - it waits for `mem_rvalid`;
  - it stores `mem_rdata` in the line as valid;
  - it raises `cpu_ready` in the next cycle with that data.
- R4: A store to a valid matching line issues an invalidate (`bus_cmd` = 3) and then, in the next cycle, a write (`bus_cmd` = 2), both to the store address. The local line takes the new data.
- R5: A store that misses issues a read, then an invalidate, then a write to the same address. The line ends valid and holds the stored data.
- R6: Replacing a valid line with a different tag issues no write for the old address. Only the new address is read.
- R7: An invalidate seen on the snoop inputs from another source number drops the line if that line is valid and its tag matches. The line is invalid from the next cycle, so a later load misses and fetches the current memory value.
- R8: A snooped invalidate with this cache's own source number has no effect. So does an invalidate whose tag differs from the line's tag, and so does any other snooped command. A later load still hits.
- R9: While `bus_req` is high and `bus_gnt` is low, `cpu_ready` stays low and `bus_cmd` stays idle. Each extra cycle of grant delay adds one cycle of stall. The arbiter keeps the grant while the request is held.
- R10: While a command is driven, `bus_src` carries the parameter `MY_ID`. Command codes are 0 idle, 1 read, 2 write, 3 invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Processor request pending; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; the low bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | Command driven on the bus |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Write data for a write command |
| bus_src | output | SRC_W | Source number of the command |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |
| snp_cmd | input | 2 | Command seen on the bus from any cache |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_src | input | SRC_W | Source number of the snooped command |

## Verification
The access path is tried with the following patterns, and each one separates a different path through the sequencer:
- a load to an empty line;
- a repeat load to the same line;
- a store to a present line;
- a store to an absent line;
- a load that displaces a line of another tag.

The exact list of bus commands each pattern produces, and the number of stall cycles, tell these paths apart.

Snoop traffic is tried in the following forms:
- a foreign invalidate, with memory changed behind the cache, so that only a real refetch returns the new value;
- an invalidate carrying the cache's own number;
- an invalidate with a different tag on the same line;
- a non-invalidate command.

A load after each of these shows by its latency whether the line survived. A delayed grant shows that the stall stretches by exactly the delay.

// File: rtl/wti_pkg.sv
`timescale 1ns/1ps
package wti_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_INVAL = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_RD, ST_RDW, ST_INV, ST_WR, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/wti_line_store.sv
`timescale 1ns/1ps
module wti_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] look_idx,
  output logic                     look_valid,
  output logic [TAG_W-1:0]         look_tag,
  output logic [DATA_W-1:0]        look_data,
  input  logic                     upd_en,
  input  logic [$clog2(LINES)-1:0] upd_idx,
  input  logic [TAG_W-1:0]         upd_tag,
  input  logic [DATA_W-1:0]        upd_data,
  input  logic                     kill_req,
  input  logic [$clog2(LINES)-1:0] kill_idx,
  input  logic [TAG_W-1:0]         kill_tag,
  output logic                     kill_hit
);
  logic [LINES-1:0]  valid_vec;
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  // a snooped kill needs a live line with the same tag
  assign kill_hit = kill_req && valid_vec[kill_idx] && (tag_arr[kill_idx] == kill_tag);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic              mine_upd, mine_kill;
    assign mine_upd  = upd_en && (upd_idx == i);
    assign mine_kill = kill_hit && (kill_idx == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else if (mine_upd) begin     // local update has priority
        v_q <= 1'b1;
        t_q <= upd_tag;
        d_q <= upd_data;
      end else if (mine_kill) begin
        v_q <= 1'b0;
      end
    end

    assign valid_vec[i] = v_q;
    assign tag_arr[i]   = t_q;
    assign data_arr[i]  = d_q;
  end

  assign look_valid = valid_vec[look_idx];
  assign look_tag   = tag_arr[look_idx];
  assign look_data  = data_arr[look_idx];
endmodule

// File: rtl/wti_seq.sv
`timescale 1ns/1ps
module wti_seq
  import wti_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter int          SRC_W  = 2,
  parameter int unsigned MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  input  logic              look_hit,
  input  logic              bus_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [SRC_W-1:0]  bus_src,
  output logic              in_idle,
  output logic [ADDR_W-1:0] req_addr,
  output logic              rd_hit_now,
  output logic              fill_en,
  output logic              upd_en,
  output logic [DATA_W-1:0] upd_data
);
  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, hit_q;
  logic              accept;

  assign in_idle    = (st_q == ST_IDLE);
  assign req_addr   = addr_q;
  assign rd_hit_now = in_idle && cpu_valid && !cpu_write && look_hit;
  assign accept     = in_idle && cpu_valid && !rd_hit_now;
  assign fill_en    = (st_q == ST_RDW) && mem_rvalid;

  always_comb begin
    st_d      = st_q;
    bus_cmd   = CMD_IDLE;
    bus_req   = 1'b0;
    cpu_ready = 1'b0;
    upd_en    = 1'b0;
    upd_data  = mem_rdata;
    unique case (st_q)
      ST_IDLE: begin
        cpu_ready = rd_hit_now;
        if (accept) st_d = ST_ARB;
      end
      ST_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) st_d = (wr_q && hit_q) ? ST_INV : ST_RD;
      end
      ST_RD: begin
        bus_req = 1'b1;
        bus_cmd = CMD_READ;
        st_d    = ST_RDW;
      end
      ST_RDW: begin
        bus_req = 1'b1;
        if (fill_en) begin
          upd_en = 1'b1;
          st_d   = wr_q ? ST_INV : ST_DONE;
        end
      end
      ST_INV: begin
        bus_req = 1'b1;
        bus_cmd = CMD_INVAL;
        st_d    = ST_WR;
      end
      ST_WR: begin
        bus_req  = 1'b1;
        bus_cmd  = CMD_WRITE;
        upd_en   = 1'b1;
        upd_data = wdata_q;
        st_d     = ST_DONE;
      end
      ST_DONE: begin
        cpu_ready = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign bus_addr  = (bus_cmd != CMD_IDLE) ? addr_q : '0;
  assign bus_wdata = (bus_cmd == CMD_WRITE) ? wdata_q : '0;
  assign bus_src   = (bus_cmd != CMD_IDLE) ? SRC_W'(MY_ID) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
        wr_q    <= cpu_write;
        hit_q   <= look_hit;
      end
    end
  end
endmodule

// File: rtl/wti_snoop_ctrl.sv
`timescale 1ns/1ps
module wti_snoop_ctrl
  import wti_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter int          LINES  = 4,
  parameter int          SRC_W  = 2,
  parameter int unsigned MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [SRC_W-1:0]  bus_src,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [SRC_W-1:0]  snp_src
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic              in_idle, look_valid, look_hit;
  logic [ADDR_W-1:0] req_addr, look_addr;
  logic [TAG_W-1:0]  look_tag;
  logic [DATA_W-1:0] look_data, upd_data;
  logic              rd_hit_now, fill_en, upd_en;
  logic              kill_req, kill_hit;

  assign look_addr = in_idle ? cpu_addr : req_addr;
  assign look_hit  = look_valid && (look_tag == tag_of(look_addr));
  assign cpu_rdata = look_data;
  assign kill_req  = (snp_cmd == CMD_INVAL) && (snp_src != SRC_W'(MY_ID));

  wti_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_idx   (idx_of(look_addr)),
    .look_valid (look_valid),
    .look_tag   (look_tag),
    .look_data  (look_data),
    .upd_en     (upd_en),
    .upd_idx    (idx_of(req_addr)),
    .upd_tag    (tag_of(req_addr)),
    .upd_data   (upd_data),
    .kill_req   (kill_req),
    .kill_idx   (idx_of(snp_addr)),
    .kill_tag   (tag_of(snp_addr)),
    .kill_hit   (kill_hit)
  );

  wti_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MY_ID(MY_ID)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .look_hit   (look_hit),
    .bus_gnt    (bus_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_src    (bus_src),
    .in_idle    (in_idle),
    .req_addr   (req_addr),
    .rd_hit_now (rd_hit_now),
    .fill_en    (fill_en),
    .upd_en     (upd_en),
    .upd_data   (upd_data)
  );
endmodule

// File: rtl/wti_snoop_ctrl_chk.sv
`timescale 1ns/1ps
module wti_snoop_ctrl_chk #(
  parameter int          SRC_W = 2,
  parameter int unsigned MY_ID = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ready,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic [1:0]       bus_cmd,
  input logic [SRC_W-1:0] bus_src,
  input logic [1:0]       snp_cmd,
  input logic [SRC_W-1:0] snp_src,
  input logic             rd_hit_now,
  input logic             fill_en,
  input logic             kill_hit
);
  p_cmd_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_gnt && bus_req));

  p_wait_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !cpu_ready);

  p_write_after_inval_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd2) |-> ($past(bus_cmd) == 2'd3));

  p_read_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_now |-> (bus_cmd == 2'd0 && !bus_req));

  p_own_id_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_cmd == 2'd3 && snp_src == SRC_W'(MY_ID)) |-> !kill_hit);

  p_src_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_src == SRC_W'(MY_ID)));

  p_fill_then_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (cpu_ready || bus_cmd == 2'd3));
endmodule

bind wti_snoop_ctrl wti_snoop_ctrl_chk #(.SRC_W(SRC_W), .MY_ID(MY_ID)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_ready  (cpu_ready),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_cmd    (bus_cmd),
  .bus_src    (bus_src),
  .snp_cmd    (snp_cmd),
  .snp_src    (snp_src),
  .rd_hit_now (rd_hit_now),
  .fill_en    (fill_en),
  .kill_hit   (kill_hit)
);

// File: tb/wti_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module wti_snoop_ctrl_bench;
  localparam int AW = 8, DW = 16, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, cpu_ready;
  logic [AW-1:0] cpu_addr = '0, bus_addr, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, bus_wdata, mem_rdata = '0;
  logic bus_req, bus_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [1:0] bus_cmd, snp_cmd = 2'd0;
  logic [SW-1:0] bus_src, snp_src = '0;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mem [256];
  logic [1:0]    log_cmd [16];
  logic [AW-1:0] log_addr [16];
  logic [SW-1:0] log_src [16];
  int log_n = 0, gnt_wait = 0, cmd_no_gnt = 0;
  logic rsp_pend = 1'b0;
  logic [AW-1:0] rsp_addr = '0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  wti_snoop_ctrl u_wti_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_src(bus_src), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src));

  // memory stub, arbiter stub and command log
  always @(negedge clk) begin
    mem_rvalid <= rsp_pend;
    mem_rdata  <= rsp_pend ? mem[rsp_addr] : '0;
    rsp_pend   = 1'b0;
    if (bus_cmd != 2'd0) begin
      if (!bus_gnt) cmd_no_gnt++;
      if (log_n < 16) begin
        log_cmd[log_n] = bus_cmd; log_addr[log_n] = bus_addr; log_src[log_n] = bus_src;
      end
      log_n++;
      if (bus_cmd == 2'd1) begin rsp_pend = 1'b1; rsp_addr = bus_addr; end
      if (bus_cmd == 2'd2) mem[bus_addr] = bus_wdata;
    end
    if (!bus_req) bus_gnt <= 1'b0;
    else if (!bus_gnt) begin
      if (gnt_wait > 0) gnt_wait--;
      else bus_gnt <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    log_n = 0;
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    #1;
    while (!cpu_ready && waits < 300) begin @(negedge clk); #1; waits++; end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_write = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [SW-1:0] s);
    @(negedge clk);
    snp_cmd = c; snp_addr = a; snp_src = s;
    @(negedge clk);
    snp_cmd = 2'd0;
  endtask

  task automatic expect_log(input string tag, input int idx, input logic [1:0] c, input logic [AW-1:0] a);
    chk({tag, " cmd"}, 32'(log_cmd[idx]), 32'(c));
    chk({tag, " addr"}, 32'(log_addr[idx]), 32'(a));
    chk({tag, " src"}, 32'(log_src[idx]), 32'd1);   // R10
  endtask

  logic [DW-1:0] rd;
  int w;

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 ready idle", 32'(cpu_ready), 0);
    chk("R1 req idle", 32'(bus_req), 0);
    chk("R1 cmd idle", 32'(bus_cmd), 0);
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R1 R3 miss latency", 32'(w), 4);
    chk("R3 bus count", 32'(log_n), 1);
    expect_log("R3 read", 0, 2'd1, 8'h12);
    chk("R3 data", 32'(rd), 32'(mem[8'h12]));
  endtask

  task automatic t_read_hit();
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R2 hit latency", 32'(w), 0);
    chk("R2 no bus", 32'(log_n), 0);
    chk("R2 data", 32'(rd), 32'(mem[8'h12]));
  endtask

  task automatic t_write_hit();
    cpu_op(1'b1, 8'h12, 16'hBEEF, rd, w);
    chk("R4 latency", 32'(w), 4);
    chk("R4 bus count", 32'(log_n), 2);
    expect_log("R4 inval", 0, 2'd3, 8'h12);
    expect_log("R4 write", 1, 2'd2, 8'h12);
    chk("R4 memory", 32'(mem[8'h12]), 32'hBEEF);
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R4 local hit", 32'(w), 0);
    chk("R4 local data", 32'(rd), 32'hBEEF);
  endtask

  task automatic t_write_miss();
    cpu_op(1'b1, 8'h25, 16'h1234, rd, w);
    chk("R5 latency", 32'(w), 6);
    chk("R5 bus count", 32'(log_n), 3);
    expect_log("R5 read", 0, 2'd1, 8'h25);
    expect_log("R5 inval", 1, 2'd3, 8'h25);
    expect_log("R5 write", 2, 2'd2, 8'h25);
    cpu_op(1'b0, 8'h25, '0, rd, w);
    chk("R5 valid after", 32'(w), 0);
    chk("R5 data", 32'(rd), 32'h1234);
  endtask

  task automatic t_evict();
    cpu_op(1'b0, 8'h16, '0, rd, w);   // same line as 0x12, other tag
    chk("R6 one command", 32'(log_n), 1);
    expect_log("R6 read new", 0, 2'd1, 8'h16);
    chk("R6 data", 32'(rd), 32'(mem[8'h16]));
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R6 old refetch", 32'(w), 4);
    chk("R6 old data", 32'(rd), 32'hBEEF);
  endtask

  task automatic t_snoop_kill();
    snoop(2'd3, 8'h12, 2'd2);
    mem[8'h12] = 16'h7777;            // another cache stored here
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R7 miss after kill", 32'(w), 4);
    chk("R7 fresh data", 32'(rd), 32'h7777);
  endtask

  task automatic t_snoop_ignored();
    snoop(2'd3, 8'h12, 2'd1);         // own number
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R8 own id hit", 32'(w), 0);
    snoop(2'd3, 8'h16, 2'd2);         // other tag
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R8 tag mismatch hit", 32'(w), 0);
    snoop(2'd1, 8'h12, 2'd2);         // a read, not invalidate
    cpu_op(1'b0, 8'h12, '0, rd, w);
    chk("R8 non-inval hit", 32'(w), 0);
    chk("R8 data", 32'(rd), 32'h7777);
  endtask

  task automatic t_stall();
    gnt_wait = 5;
    cpu_op(1'b0, 8'h33, '0, rd, w);
    chk("R9 stretched latency", 32'(w), 9);
    chk("R9 single read", 32'(log_n), 1);
    chk("R9 no cmd ungranted", 32'(cmd_no_gnt), 0);
    chk("R9 data", 32'(rd), 32'(mem[8'h33]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 16'h0100);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_evict();
    t_snoop_kill();
    t_snoop_ignored();
    t_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule